// File: doc/BRIEF.md
# Dual Interval Timer Interrupt Unit

This block provides two programmable 8-bit interval timers for the register interface of a sound-synthesis engine. Software writes a count byte per timer and a control byte through a byte-wide write port (address plus data). Both timers step on a common time base that is derived from the master clock by a fixed divider. Timer A advances its interval by four base ticks per unit of (256 - count), and timer B by sixteen. When a timer's interval runs out it raises a sticky flag and reloads itself. Any raised flag drives the interrupt output.

The control byte has two forms. With its top bit set, it only wipes every pending flag. With its top bit clear, it sets the run state of both timers and clears the flags that it selects. A timer starts over with a full interval only on a 0-to-1 change of its run bit. A count written while the timer runs does not alter the interval already under way; it takes effect at the next reload. The flags and the interrupt are presented on a status byte that the surrounding read logic returns.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both run bits, both counts and both flags are zero, so status reads 0x00 and irq is low.
- R2: Timer A, once started, sets its flag (status bit 6) exactly (256 - count_a) * 4 base ticks after the write that started it, where one base tick lasts BASE_DIV clock cycles.
- R3: Timer B, once started, sets its flag (status bit 5) exactly (256 - count_b) * 16 base ticks after the write that started it.
- R4: An expired timer reloads at once and expires again one full period later for as long as it runs.
- R5: A count written (address 0x02 for A, 0x03 for B) while its timer runs leaves the interval in progress unchanged; the new period applies from the next reload.
- R6: Writing a count register with the value it already holds changes no timing.
- R7: A control write (address 0x04) with data bit 7 set clears both flags and leaves the run bits and timer progress unchanged.
- R8: A control write with bit 7 clear takes bit 0 as the run bit of timer A and bit 1 as that of timer B; a 0-to-1 change restarts the timer with a full period, and a bit that stays 1 does not disturb it.
- R9: A timer whose run bit is 0 never sets its flag.
- R10: A control write with bit 7 clear clears the A flag if data bit 6 is set and the B flag if data bit 5 is set, and leaves unselected flags as they were.
- R11: irq is high exactly while at least one flag is set; status bit 7 equals irq and status bits 4 to 0 read zero.
- R12: Writes to any address other than 0x02, 0x03 and 0x04 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Register data of the write |
| irq | output | 1 | Interrupt, high while any flag is set |
| status | output | 8 | {irq, flag A, flag B, 5'b0} |

## Verification
The main instance is built with BASE_DIV set to 1, so each base tick is one clock cycle and even the longest timer B interval (4096 ticks) fits in a short run; this makes every expiry land on a cycle the bench predicts exactly, which exposes any off-by-one in restart, reload and count-change handling. A second instance keeps the divider at 5 and is checked only on the spacing between two consecutive timer A expiries, which must be 20 cycles whatever the divider's phase, so the divider path is covered as well. Steps A and B keep their default values of 4 and 16.

// File: rtl/dit_pkg.sv
`timescale 1ns/1ps
package dit_pkg;

    localparam int CNT_W      = 8;
    localparam int NUM_TMR    = 2;
    localparam int TMR_A      = 0;
    localparam int TMR_B      = 1;
    localparam int FLAG_BIT_A = 6;
    localparam int FLAG_BIT_B = 5;
    localparam int WIPE_BIT   = 7;

    typedef enum logic [7:0] {
        ADDR_CNT_A = 8'h02,
        ADDR_CNT_B = 8'h03,
        ADDR_CTRL  = 8'h04
    } reg_addr_e;

    typedef struct packed {
        logic               wipe;
        logic [NUM_TMR-1:0] run;
        logic [NUM_TMR-1:0] clr;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic [7:0] d);
        ctrl_cmd_t c;
        c.wipe       = d[WIPE_BIT];
        c.run        = d[NUM_TMR-1:0];
        c.clr[TMR_A] = d[FLAG_BIT_A] | d[WIPE_BIT];
        c.clr[TMR_B] = d[FLAG_BIT_B] | d[WIPE_BIT];
        return c;
    endfunction

    function automatic logic [7:0] count_addr(input int idx);
        return (idx == TMR_A) ? 8'(ADDR_CNT_A) : 8'(ADDR_CNT_B);
    endfunction

    function automatic logic [7:0] pack_status(input logic irq,
                                               input logic [NUM_TMR-1:0] flg);
        return {irq, flg[TMR_A], flg[TMR_B], 5'b0};
    endfunction

endpackage

// File: rtl/dit_prescaler.sv
`timescale 1ns/1ps
module dit_prescaler #(
    parameter int DIV = 684
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dit_timer.sv
`timescale 1ns/1ps
module dit_timer #(
    parameter int STEP  = 4,
    parameter int REM_W = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       run,
    input  logic       start,
    input  logic [7:0] count,
    output logic       expire
);
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] reload;

    // full interval in base ticks, taken from the count at load time
    assign reload = REM_W'((32'd256 - 32'(count)) * 32'(STEP));
    assign expire = run && base_tick && (rem_q == REM_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (start) begin
            rem_q <= reload;
        end else if (run && base_tick) begin
            rem_q <= (rem_q == REM_W'(1)) ? reload : rem_q - 1'b1;
        end
    end
endmodule

// File: rtl/dit_regs.sv
`timescale 1ns/1ps
module dit_regs
    import dit_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_addr,
    input  logic [7:0]                    wr_data,
    input  logic [NUM_TMR-1:0]            expire,
    output logic [NUM_TMR-1:0][CNT_W-1:0] count_q,
    output logic [NUM_TMR-1:0]            run_q,
    output logic [NUM_TMR-1:0]            start,
    output logic [NUM_TMR-1:0]            flag_q
);
    ctrl_cmd_t          cmd;
    logic               is_ctrl;
    logic [NUM_TMR-1:0] flag_clr;

    assign cmd      = decode_ctrl(wr_data);
    assign is_ctrl  = wr_en && (wr_addr == 8'(ADDR_CTRL));
    assign start    = (is_ctrl && !cmd.wipe) ? (cmd.run & ~run_q) : '0;
    assign flag_clr = is_ctrl ? cmd.clr : '0;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                count_q[i] <= '0;
            else if (wr_en && (wr_addr == count_addr(i)))
                count_q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (is_ctrl && !cmd.wipe)
                run_q <= cmd.run;
            // a fresh expiry wins over a clear on the same edge
            flag_q <= (flag_q & ~flag_clr) | expire;
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int BASE_DIV = 684,
    parameter int A_STEP   = 4,
    parameter int B_STEP   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       irq,
    output logic [7:0] status
);
    localparam int MAX_STEP = (A_STEP > B_STEP) ? A_STEP : B_STEP;
    localparam int REM_W    = $clog2(256 * MAX_STEP + 1);

    logic                          base_tick;
    logic [NUM_TMR-1:0][CNT_W-1:0] count_q;
    logic [NUM_TMR-1:0]            run_q;
    logic [NUM_TMR-1:0]            start;
    logic [NUM_TMR-1:0]            flag_q;
    logic [NUM_TMR-1:0]            expire;

    dit_prescaler #(.DIV(BASE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (base_tick)
    );

    dit_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .expire  (expire),
        .count_q (count_q),
        .run_q   (run_q),
        .start   (start),
        .flag_q  (flag_q)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        dit_timer #(
            .STEP  ((i == TMR_A) ? A_STEP : B_STEP),
            .REM_W (REM_W)
        ) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .base_tick (base_tick),
            .run       (run_q[i]),
            .start     (start[i]),
            .count     (count_q[i]),
            .expire    (expire[i])
        );
    end

    assign irq    = |flag_q;
    assign status = pack_status(irq, flag_q);
endmodule

// File: rtl/dit_checker.sv
`timescale 1ns/1ps
module dit_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       irq,
    input logic [7:0] status,
    input logic [1:0] run,
    input logic [1:0] flags,
    input logic [1:0] expire
);
    logic is_ctrl;
    assign is_ctrl = wr_en && (wr_addr == 8'h04);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (status == 8'h00 && !irq));

    p_flag_a_from_expiry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> $past(expire[0]));

    p_flag_b_from_expiry_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> $past(expire[1]));

    p_wipe_keeps_run_r7: assert property (@(posedge clk) disable iff (rst)
        (is_ctrl && wr_data[7] && expire == 2'b00) |=> (flags == 2'b00 && $stable(run)));

    p_stopped_a_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (!run[0] && !flags[0]) |=> !flags[0]);

    p_stopped_b_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (!run[1] && !flags[1]) |=> !flags[1]);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !is_ctrl) |=> flags[0]);

    p_foreign_addr_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 8'h04) |=> $stable(run));
endmodule

bind dual_interval_timer dit_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq),
    .status  (status),
    .run     (run_q),
    .flags   (flag_q),
    .expire  (expire)
);

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq;
    logic [7:0] status;
    logic       wr2_en = 1'b0;
    logic [7:0] wr2_addr = '0;
    logic [7:0] wr2_data = '0;
    logic       irq2;
    logic [7:0] status2;

    always #2 clk = ~clk;

    dual_interval_timer #(.BASE_DIV(1)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq), .status(status));

    dual_interval_timer #(.BASE_DIV(5)) u_dut_slow (
        .clk(clk), .rst(rst), .wr_en(wr2_en), .wr_addr(wr2_addr),
        .wr_data(wr2_data), .irq(irq2), .status(status2));

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int unsigned at;
        logic [7:0]  st;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic push(input int unsigned at, input logic [7:0] st, input string tag);
        exp_t e;
        e.at = at; e.st = st; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares status and irq in the cycle each expectation names
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc) begin
                fails++;
                $display("FAIL %s: check for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
            end else if (status !== e.st || irq !== e.st[7]) begin
                fails++;
                $display("FAIL %s @%0d: status=%02h irq=%b expected status=%02h irq=%b",
                         e.tag, cyc, status, irq, e.st, e.st[7]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output int unsigned w);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        w = cyc;
        wr_en = 1'b0;
    endtask

    task automatic wr2(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr2_en = 1'b1; wr2_addr = a; wr2_data = d;
        @(negedge clk);
        wr2_en = 1'b0;
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not end, cycle=%0d expected end before 200000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned w, w2, w3, w4, w5, w6, w7, w9, w10, wa, wb, wc, wd, we, t1, t2, tmp;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        push(cyc + 2, 8'h00, "R1");
        wait_until(cyc + 3);

        // timer A: count 250 -> 24 ticks
        wr(8'h02, 8'd250, tmp);
        wr(8'h04, 8'h01, w);
        push(w + 23, 8'h00, "R2");
        push(w + 24, 8'hC0, "R2");
        wait_until(w + 26);
        wr(8'h04, 8'h41, w2);           // clear A flag, run bit stays 1
        push(w2 + 1, 8'h00, "R10");
        push(w + 47, 8'h00, "R8");
        push(w + 48, 8'hC0, "R4");

        // count change while running: current interval keeps 24
        wait_until(w + 49);
        wr(8'h04, 8'h80, w3);
        push(w3 + 1, 8'h00, "R7");
        wr(8'h02, 8'd252, w4);
        push(w + 71, 8'h00, "R5");
        push(w + 72, 8'hC0, "R5");
        wait_until(w + 73);
        wr(8'h04, 8'h80, w5);
        push(w5 + 1, 8'h00, "R7");
        push(w + 87, 8'h00, "R5");
        push(w + 88, 8'hC0, "R5");

        // same value rewrite
        wait_until(w + 89);
        wr(8'h04, 8'h80, w6);
        push(w6 + 1, 8'h00, "R7");
        wr(8'h02, 8'd252, w7);
        push(w + 103, 8'h00, "R6");
        push(w + 104, 8'hC0, "R6");

        // stop, then restart from a full period
        wait_until(w + 105);
        wr(8'h04, 8'h80, tmp);
        wr(8'h04, 8'h00, w9);
        push(w9 + 1, 8'h00, "R9");
        push(w9 + 40, 8'h00, "R9");
        wait_until(w9 + 41);
        wr(8'h04, 8'h01, w10);
        push(w10 + 15, 8'h00, "R8");
        push(w10 + 16, 8'hC0, "R8");

        // timer B: count 255 -> 16 ticks
        wait_until(w10 + 17);
        wr(8'h04, 8'h40, wa);
        push(wa + 1, 8'h00, "R10");
        wr(8'h03, 8'd255, tmp);
        wr(8'h04, 8'h02, wb);
        push(wb + 15, 8'h00, "R3");
        push(wb + 16, 8'hA0, "R3");
        push(wb + 32, 8'hA0, "R4");
        wait_until(wb + 33);
        wr(8'h04, 8'h03, wc);           // A restarts, B keeps running
        push(wc + 15, 8'hA0, "R11");
        push(wc + 16, 8'hE0, "R11");
        wait_until(wc + 17);
        wr(8'h04, 8'h21, wd);           // stop B, clear B flag only
        push(wd + 1, 8'hC0, "R10");
        push(wd + 40, 8'hC0, "R9");

        // foreign addresses
        wait_until(wd + 41);
        wr(8'h05, 8'h02, tmp);
        wr(8'h06, 8'h80, we);
        push(we + 1, 8'hC0, "R12");
        push(we + 60, 8'hC0, "R12");
        wait_until(we + 61);

        // divided time base on the second instance
        wr2(8'h02, 8'd255);
        wr2(8'h04, 8'h01);
        while (!status2[6]) @(negedge clk);
        t1 = cyc;
        wr2(8'h04, 8'h41);
        chk(status2 == 8'h00, "R10", int'(status2), 0);
        while (!status2[6]) @(negedge clk);
        t2 = cyc;
        chk((t2 - t1) == 20, "R2", int'(t2 - t1), 20);
        chk(irq2 == 1'b1, "R11", int'(irq2), 1);

        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule